// File: doc/BRIEF.md
# Configurable Logic Cell with Selectable Register Type

This cell receives four sum-of-products terms from a surrounding logic array, here named `sum_a` to `sum_d`, together with a few signals shared by every cell. It holds one storage bit. That bit can behave as a D, T or JK flip-flop, and a shared mode line can switch it at run time between D behaviour (load) and T behaviour (count). Static configuration inputs set the role of each sum term:

- `sum_a` is the data, toggle or J input.
- `sum_b` is the K input and may also act as a preset.
- `sum_c` may act as the clock or as a reset.
- `sum_d` may act as the clock or as an output enable.

The cell runs on a fast system clock `clk`. It watches the selected cell clock source and changes the register when that source rises. The source is `sum_c`, `sum_d`, or the shared clock with selectable polarity.

Reset and preset come either from the shared lines or from the local sum terms. They act on the visible register value at once, without waiting for an edge, and they override any clock edge. Two independent outputs each route either the register value or one of the combinational terms A, B or C. One output feeds back into the array and the other goes toward an I/O cell. A third output is the output enable.

Top module: `lcc_cell`

## Requirements
- R1: With `cfg_kind`=0 (D) or 3 (also D), a rising edge of the selected clock source loads `sum_a` into the register.
- R2: With `cfg_kind`=1 (T), a rising edge inverts the register when `sum_a`=1 and keeps it when `sum_a`=0.
- R3: With `cfg_kind`=2 (JK), J=`sum_a` and K=`sum_b`. On a rising edge the register behaves as follows:
  - J=1, K=0 sets it to 1.
  - J=0, K=1 clears it to 0.
  - J=1, K=1 inverts it.
  - J=0, K=0 keeps it.
- R4: `cfg_clk_src` picks the cell clock source: 0 is `sum_c`, 1 is `sum_d`, and 2 or 3 is `glb_clk` XOR `cfg_glb_clk_inv`. An edge is counted on the first `clk` cycle where the source is 1 after a cycle where it was 0. A source already high when `rst_n` is released does not count as an edge.
- R5: The active reset is `glb_reset` OR (`cfg_c_reset_en` AND `sum_c`). The active preset is `glb_preset` OR (`cfg_b_preset_en` AND `sum_b`).
  - An active reset forces the visible register value to 0 in the same cycle, and the value stays 0 after the reset ends.
  - An active preset forces the value to 1 in the same way.
  - When both are active, reset wins.
  - Reset and preset both override any clock edge.
- R6: When `cfg_dyn_en`=1, the register uses T behaviour while `glb_toggle_mode`=1 and D behaviour while it is 0, whatever `cfg_kind` holds.
- R7: `cfg_fb_sel` and `cfg_io_sel` each pick their output on their own: 0 is the register value, 1 is `sum_a`, 2 is `sum_b`, 3 is `sum_c`.
- R8: `io_oe` equals `sum_d` when `cfg_d_oe_en`=1, and is 1 otherwise.
- R9: While `rst_n` is low, the stored bit is cleared to 0 and the clock history is taken as high.
- R10: Without a counted edge, reset or preset, the register value does not change, whatever the data terms do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every term |
| rst_n | input | 1 | Active-low system reset |
| sum_a | input | 1 | Sum term A: D, T or J input |
| sum_b | input | 1 | Sum term B: K input or local preset |
| sum_c | input | 1 | Sum term C: clock or local reset |
| sum_d | input | 1 | Sum term D: clock or output enable |
| glb_clk | input | 1 | Shared clock line |
| glb_preset | input | 1 | Shared preset |
| glb_reset | input | 1 | Shared reset |
| glb_toggle_mode | input | 1 | Shared run-time D/T selector |
| cfg_kind | input | 2 | Register type: 0 D, 1 T, 2 JK, 3 D |
| cfg_dyn_en | input | 1 | Let `glb_toggle_mode` choose the type |
| cfg_clk_src | input | 2 | Clock source choice |
| cfg_glb_clk_inv | input | 1 | Invert the shared clock |
| cfg_c_reset_en | input | 1 | Use `sum_c` as a local reset |
| cfg_b_preset_en | input | 1 | Use `sum_b` as a local preset |
| cfg_d_oe_en | input | 1 | Use `sum_d` as output enable |
| cfg_fb_sel | input | 2 | Feedback output source |
| cfg_io_sel | input | 2 | I/O output source |
| fb_out | output | 1 | Output back into the array |
| io_out | output | 1 | Output toward the I/O cell |
| io_oe | output | 1 | Output enable for the I/O cell |

## Verification
The terms are driven with random values while the configuration is held steady in each run. This covers D, T and JK behaviour, each clock source and both polarities of the shared clock.

- A run with `sum_c` held low separates a correct hold from spurious updates.
- A run that holds the clock source high across reset release shows whether a level is wrongly taken as an edge.
- Runs with sparse shared resets and presets, plus local ones from `sum_b` and `sum_c`, expose a wrong priority, since reset and preset then often coincide.
- Runs where `glb_toggle_mode` is random tell apart a cell that obeys the mode line from one that keeps the JK type set in `cfg_kind`.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        KIND_D  = 2'd0,
        KIND_T  = 2'd1,
        KIND_JK = 2'd2,
        KIND_D2 = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        CK_SUM_C   = 2'd0,
        CK_SUM_D   = 2'd1,
        CK_GLOBAL  = 2'd2,
        CK_GLOBAL2 = 2'd3
    } clk_pick_e;

    typedef enum logic [1:0] {
        RT_Q = 2'd0,
        RT_A = 2'd1,
        RT_B = 2'd2,
        RT_C = 2'd3
    } route_e;

    typedef struct packed {
        logic q;
        logic clk_prev;
    } cell_state_t;

endpackage

// File: rtl/lcc_clock_pick.sv
module lcc_clock_pick
    import lcc_pkg::*;
(
    input  clk_pick_e pick,
    input  logic      sum_c,
    input  logic      sum_d,
    input  logic      glb_clk,
    input  logic      glb_inv,
    output logic      src
);
    always_comb begin
        case (pick)
            CK_SUM_C: src = sum_c;
            CK_SUM_D: src = sum_d;
            default:  src = glb_clk ^ glb_inv;
        endcase
    end
endmodule

// File: rtl/lcc_reg_next.sv
module lcc_reg_next
    import lcc_pkg::*;
(
    input  reg_kind_e kind,
    input  logic      q,
    input  logic      in_a,
    input  logic      in_b,
    output logic      q_next
);
    always_comb begin
        case (kind)
            KIND_T:  q_next = q ^ in_a;
            KIND_JK: begin
                case ({in_a, in_b})
                    2'b10:   q_next = 1'b1;
                    2'b01:   q_next = 1'b0;
                    2'b11:   q_next = ~q;
                    default: q_next = q;
                endcase
            end
            default: q_next = in_a;
        endcase
    end
endmodule

// File: rtl/lcc_out_route.sv
module lcc_out_route
    import lcc_pkg::*;
#(
    parameter int NUM_OUTS = 2
) (
    input  route_e              sel [NUM_OUTS],
    input  logic                q,
    input  logic                in_a,
    input  logic                in_b,
    input  logic                in_c,
    output logic [NUM_OUTS-1:0] y
);
    for (genvar gi = 0; gi < NUM_OUTS; gi++) begin : g_route
        always_comb begin
            case (sel[gi])
                RT_A:    y[gi] = in_a;
                RT_B:    y[gi] = in_b;
                RT_C:    y[gi] = in_c;
                default: y[gi] = q;
            endcase
        end
    end
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
    import lcc_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_a,
    input  logic             sum_b,
    input  logic             sum_c,
    input  logic             sum_d,
    input  logic             glb_clk,
    input  logic             glb_preset,
    input  logic             glb_reset,
    input  logic             glb_toggle_mode,
    input  logic [SEL_W-1:0] cfg_kind,
    input  logic             cfg_dyn_en,
    input  logic [SEL_W-1:0] cfg_clk_src,
    input  logic             cfg_glb_clk_inv,
    input  logic             cfg_c_reset_en,
    input  logic             cfg_b_preset_en,
    input  logic             cfg_d_oe_en,
    input  logic [SEL_W-1:0] cfg_fb_sel,
    input  logic [SEL_W-1:0] cfg_io_sel,
    output logic             fb_out,
    output logic             io_out,
    output logic             io_oe
);
    localparam int NUM_OUTS = 2;
    localparam cell_state_t RESET_STATE = '{q: 1'b0, clk_prev: 1'b1};

    cell_state_t          st_q, st_d;
    reg_kind_e            kind_eff;
    logic                 clk_src;
    logic                 edge_seen;
    logic                 rst_act;
    logic                 pre_act;
    logic                 q_vis;
    logic                 q_step;
    route_e               route_sel [NUM_OUTS];
    logic [NUM_OUTS-1:0]  route_y;

    // Run-time D/T switching overrides the static type.
    always_comb begin
        if (cfg_dyn_en) kind_eff = glb_toggle_mode ? KIND_T : KIND_D;
        else            kind_eff = reg_kind_e'(cfg_kind);
    end

    lcc_clock_pick u_clock_pick (
        .pick    (clk_pick_e'(cfg_clk_src)),
        .sum_c   (sum_c),
        .sum_d   (sum_d),
        .glb_clk (glb_clk),
        .glb_inv (cfg_glb_clk_inv),
        .src     (clk_src)
    );

    lcc_reg_next u_reg_next (
        .kind   (kind_eff),
        .q      (st_q.q),
        .in_a   (sum_a),
        .in_b   (sum_b),
        .q_next (q_step)
    );

    always_comb begin
        rst_act   = glb_reset  | (cfg_c_reset_en  & sum_c);
        pre_act   = glb_preset | (cfg_b_preset_en & sum_b);
        edge_seen = clk_src & ~st_q.clk_prev;
        // Forces act on the visible value without waiting for an edge.
        if (rst_act)      q_vis = 1'b0;
        else if (pre_act) q_vis = 1'b1;
        else              q_vis = st_q.q;

        st_d          = st_q;
        st_d.clk_prev = clk_src;
        if (rst_act)        st_d.q = 1'b0;
        else if (pre_act)   st_d.q = 1'b1;
        else if (edge_seen) st_d.q = q_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign route_sel[0] = route_e'(cfg_fb_sel);
    assign route_sel[1] = route_e'(cfg_io_sel);

    lcc_out_route #(.NUM_OUTS(NUM_OUTS)) u_out_route (
        .sel  (route_sel),
        .q    (q_vis),
        .in_a (sum_a),
        .in_b (sum_b),
        .in_c (sum_c),
        .y    (route_y)
    );

    assign fb_out = route_y[0];
    assign io_out = route_y[1];
    assign io_oe  = cfg_d_oe_en ? sum_d : 1'b1;

endmodule

// File: rtl/lcc_cell_chk.sv
module lcc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sum_a,
    input logic       sum_b,
    input logic       sum_c,
    input logic       sum_d,
    input logic       glb_preset,
    input logic       glb_reset,
    input logic [1:0] cfg_clk_src,
    input logic       cfg_c_reset_en,
    input logic       cfg_b_preset_en,
    input logic       cfg_d_oe_en,
    input logic [1:0] cfg_fb_sel,
    input logic [1:0] cfg_io_sel,
    input logic       fb_out,
    input logic       io_out,
    input logic       io_oe
);
    logic rst_now, pre_now;
    logic prev_c_q, edge_c_q, force_q, live_q;

    assign rst_now = glb_reset  | (cfg_c_reset_en  & sum_c);
    assign pre_now = glb_preset | (cfg_b_preset_en & sum_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_c_q <= 1'b1;
            edge_c_q <= 1'b0;
            force_q  <= 1'b0;
            live_q   <= 1'b0;
        end else begin
            prev_c_q <= sum_c;
            edge_c_q <= sum_c & ~prev_c_q;
            force_q  <= rst_now | pre_now;
            live_q   <= 1'b1;
        end
    end

    assert_reset_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_now && cfg_fb_sel == 2'd0) |-> (fb_out == 1'b0));

    assert_preset_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_now && !rst_now && cfg_io_sel == 2'd0) |-> (io_out == 1'b1));

    assert_oe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe == (cfg_d_oe_en ? sum_d : 1'b1));

    assert_route_comb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_io_sel == 2'd1) |-> (io_out == sum_a));

    assert_route_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fb_sel == 2'd3) |-> (fb_out == sum_c));

    assert_hold_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && cfg_clk_src == 2'd0 && cfg_fb_sel == 2'd0 && !cfg_c_reset_en &&
         !edge_c_q && !force_q && !rst_now && !pre_now) |-> $stable(fb_out));

endmodule

bind lcc_cell lcc_cell_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sum_a           (sum_a),
    .sum_b           (sum_b),
    .sum_c           (sum_c),
    .sum_d           (sum_d),
    .glb_preset      (glb_preset),
    .glb_reset       (glb_reset),
    .cfg_clk_src     (cfg_clk_src),
    .cfg_c_reset_en  (cfg_c_reset_en),
    .cfg_b_preset_en (cfg_b_preset_en),
    .cfg_d_oe_en     (cfg_d_oe_en),
    .cfg_fb_sel      (cfg_fb_sel),
    .cfg_io_sel      (cfg_io_sel),
    .fb_out          (fb_out),
    .io_out          (io_out),
    .io_oe           (io_oe)
);

// File: tb/lcc_cell_bench.sv
module lcc_cell_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
    logic glb_clk = 0, glb_preset = 0, glb_reset = 0, glb_toggle_mode = 0;
    logic [1:0] cfg_kind = 0, cfg_clk_src = 0, cfg_fb_sel = 0, cfg_io_sel = 0;
    logic cfg_dyn_en = 0, cfg_glb_clk_inv = 0, cfg_c_reset_en = 0;
    logic cfg_b_preset_en = 0, cfg_d_oe_en = 0;
    logic fb_out, io_out, io_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int m_state  = 0;
    int m_prev   = 1;

    always #10 clk = ~clk;

    lcc_cell u_lcc_cell (.*);

    function automatic int m_src();
        case (cfg_clk_src)
            2'd0:    return int'(sum_c);
            2'd1:    return int'(sum_d);
            default: return int'(glb_clk ^ cfg_glb_clk_inv);
        endcase
    endfunction

    function automatic int m_rst();
        return int'(glb_reset || (cfg_c_reset_en && sum_c));
    endfunction

    function automatic int m_pre();
        return int'(glb_preset || (cfg_b_preset_en && sum_b));
    endfunction

    function automatic int m_visible();
        if (m_rst() != 0) return 0;
        if (m_pre() != 0) return 1;
        return m_state;
    endfunction

    function automatic int m_route(input logic [1:0] sel);
        case (sel)
            2'd1:    return int'(sum_a);
            2'd2:    return int'(sum_b);
            2'd3:    return int'(sum_c);
            default: return m_visible();
        endcase
    endfunction

    function automatic int m_after_edge();
        int kind;
        int j, k;
        kind = (cfg_dyn_en) ? (glb_toggle_mode ? 1 : 0) : int'(cfg_kind);
        j = int'(sum_a);
        k = int'(sum_b);
        if (kind == 1) return (j != 0) ? 1 - m_state : m_state;
        if (kind == 2) begin
            if (j == 1 && k == 0) return 1;
            if (j == 0 && k == 1) return 0;
            if (j == 1 && k == 1) return 1 - m_state;
            return m_state;
        end
        return j;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Inputs are stable after a falling edge; compare, then advance the model over the rising edge.
    task automatic step(input string tag);
        int src;
        #2;
        check(tag, "fb_out", int'(fb_out), m_route(cfg_fb_sel));
        check(tag, "io_out", int'(io_out), m_route(cfg_io_sel));
        check("R8", "io_oe", int'(io_oe), cfg_d_oe_en ? int'(sum_d) : 1);
        @(posedge clk);
        src = m_src();
        if (m_rst() != 0)                    m_state = 0;
        else if (m_pre() != 0)               m_state = 1;
        else if (src == 1 && m_prev == 0)    m_state = m_after_edge();
        m_prev = src;
        @(negedge clk);
    endtask

    task automatic burst(input string tag, input int n, input bit rnd_rst,
                         input bit rnd_pre, input bit rnd_sel, input bit hold_c);
        for (int i = 0; i < n; i++) begin
            sum_a = 1'($urandom_range(0, 1));
            sum_b = 1'($urandom_range(0, 1));
            sum_c = hold_c ? 1'b0 : 1'($urandom_range(0, 1));
            sum_d = 1'($urandom_range(0, 1));
            glb_clk = 1'($urandom_range(0, 1));
            glb_toggle_mode = 1'($urandom_range(0, 1));
            glb_reset  = rnd_rst && ($urandom_range(0, 5) == 0);
            glb_preset = rnd_pre && ($urandom_range(0, 4) == 0);
            if (rnd_sel) begin
                cfg_fb_sel  = 2'($urandom_range(0, 3));
                cfg_io_sel  = 2'($urandom_range(0, 3));
                cfg_d_oe_en = 1'($urandom_range(0, 1));
            end
            step(tag);
        end
        glb_reset = 0;
        glb_preset = 0;
    endtask

    task automatic setup(input logic [1:0] kind, input logic [1:0] src, input logic inv,
                         input logic dyn, input logic crst, input logic bpre);
        cfg_kind = kind; cfg_clk_src = src; cfg_glb_clk_inv = inv;
        cfg_dyn_en = dyn; cfg_c_reset_en = crst; cfg_b_preset_en = bpre;
        cfg_fb_sel = 2'd0; cfg_io_sel = 2'd0; cfg_d_oe_en = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R9 / R4: clock source and data high across reset release
        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        sum_a = 1; sum_c = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R9");
        for (int i = 0; i < 3; i++) step("R4");
        sum_c = 0;
        step("R4");
        sum_c = 1;
        step("R1");
        step("R1");

        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); burst("R1", 60, 0, 0, 0, 0);
        setup(2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); burst("R1", 30, 0, 0, 0, 0);
        setup(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); burst("R2", 60, 0, 0, 0, 0);
        setup(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); burst("R3", 80, 0, 0, 0, 0);
        setup(2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0); burst("R4", 60, 0, 0, 0, 0);
        setup(2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); burst("R6", 80, 0, 0, 0, 0);
        setup(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); burst("R5", 60, 1, 1, 0, 0);
        setup(2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1); burst("R5", 60, 1, 1, 0, 0);
        setup(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); burst("R7", 80, 0, 0, 1, 0);
        setup(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); burst("R10", 40, 0, 0, 0, 1);
        setup(2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); burst("R10", 30, 0, 0, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule